// File: doc/BRIEF.md
# Replay-Capable Variable-Latency Memory Access Unit

This block is the memory stage of a multithreaded in-order pipeline. An access is offered with `start_i`, a thread tag and a line address. A small direct-mapped tag table decides hit or miss. A hit completes in the cycle it is offered. A miss takes a fixed number of cycles (ten by default) to fill the line.

On a miss the unit has two options. If replay is currently allowed, it cancels the access and raises a replay request carrying the thread tag. The pipeline then re-issues that thread later and lets other threads run, while the line fill carries on in the background. If replay is forbidden through the dynamic `no_replay_i` input, the unit drops `ready_o` and holds the access until the fill ends. Only one fill is in flight at a time. A miss that arrives while a fill is outstanding does not start a second one.

Replay requests from the other pipeline stages arrive on a peer vector. The unit's own request is merged in at its configured stage position. An arbiter picks the request from the latest stage and outputs that thread tag with a replay-enable flag.

Top module: `mlu_top`

## Requirements
- R1: After reset `ready_o`=1, `done_o`=0, `unit_replay_o`=0, `replay_en_o`=0, and every tag entry is invalid, so the first access to any line misses.
- R2: An access whose line is present completes in the same cycle as `start_i` (`done_o`=1, no replay), and `ready_o` stays 1.
- R3: A miss offered with `no_replay_i`=1 while no fill is outstanding raises no replay. `ready_o` is 0 in cycles c0+1..c0+10 and `done_o` is 1 only in cycle c0+10, where c0 is the start cycle. `ready_o` returns to 1 in cycle c0+11, and the line then hits.
- R4: A miss offered with `no_replay_i`=0 raises `unit_replay_o` in the start cycle, with `done_o`=0 and `ready_o` kept at 1. The replay is cancelled work: the unit accepts a new access in the next cycle.
- R5: The fill caused by a replayed miss continues in the background. The line is written into the table at the end of cycle c0+10, so an access to it in c0+10 still misses and one in c0+11 hits.
- R6: A miss while a fill is outstanding starts no second fill. After the first fill ends, its line hits and the second line still misses.
- R7: A stalled miss (`no_replay_i`=1) to the line already being filled completes when that fill ends. A stalled miss to another line waits for that fill to end, starts its own fill in the next cycle, and completes ten cycles later.
- R8: While `ready_o`=0, `start_i` is ignored: it yields no `done_o` and no replay.
- R9: The replay arbiter grants the highest-numbered requesting stage (the latest stage). `replay_tid_o` is that stage's thread tag, and `replay_stage_o` is its index. With no request, `replay_en_o`, `replay_tid_o` and `replay_stage_o` are 0.
- R10: The unit's own request joins stage `UNIT_STAGE` (default 2). It loses to a peer request from a later stage. At its own stage it replaces the peer's thread tag with `tid_i`.
- R11: The tag table is direct mapped: index = address bits [IDX_W-1:0], tag = the remaining upper bits. A fill replaces the previous line at that index, which then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Access offered this cycle |
| tid_i | input | TID_W | Thread tag of the access |
| addr_i | input | ADDR_W | Line address of the access |
| no_replay_i | input | 1 | Replay forbidden for an access offered this cycle |
| peer_req_i | input | NUM_STAGES | Replay requests from the other pipeline stages, bit s = stage s |
| peer_tid_i | input | NUM_STAGES*TID_W | Thread tags of peer requests, stage s at bits [s*TID_W +: TID_W] |
| ready_o | output | 1 | Unit can accept an access |
| done_o | output | 1 | Access completes this cycle |
| unit_replay_o | output | 1 | This unit requests replay of the offered access |
| replay_en_o | output | 1 | A replay is requested by some stage |
| replay_tid_o | output | TID_W | Thread tag of the granted replay |
| replay_stage_o | output | STG_W | Stage index of the granted replay |

## Verification
The bench builds the block with its defaults: an 8-bit line address, 2 index bits (four table entries), 2-bit thread tags, a 10-cycle miss and four stages with the unit at stage 2. With only four entries, index aliasing (R11) can be reached with chosen addresses such as 0x4A and 0x56. The short, fixed miss latency lets the bench count the exact cycle of every fill completion, including a stalled miss queued behind another line's fill (done at c0+21). Stage 3 above the unit's stage 2 lets both the losing and the winning side of the merge (R10) be observed.

// File: rtl/mlu_pkg.sv
package mlu_pkg;

  typedef enum logic {
    UNIT_IDLE  = 1'b0,
    UNIT_STALL = 1'b1
  } unit_state_e;

  function automatic int unsigned idx_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/mlu_tag_table.sv
module mlu_tag_table #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_hit_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i
);

  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned TAG_W   = ADDR_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [ENTRIES-1:0] valid_d;
  logic [ENTRIES-1:0] tag_we;
  logic [TAG_W-1:0]   tag_q [ENTRIES];

  logic [IDX_W-1:0]   lk_idx;
  logic [TAG_W-1:0]   lk_tag;
  logic [IDX_W-1:0]   wr_idx;
  logic [TAG_W-1:0]   wr_tag;

  assign lk_idx = lk_addr_i[IDX_W-1:0];
  assign lk_tag = lk_addr_i[ADDR_W-1:IDX_W];
  assign wr_idx = wr_addr_i[IDX_W-1:0];
  assign wr_tag = wr_addr_i[ADDR_W-1:IDX_W];

  // per-entry write decode
  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign tag_we[e] = wr_en_i && (wr_idx == IDX_W'(e));
  end

  always_comb begin
    valid_d = valid_q | tag_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (tag_we[e]) begin
        tag_q[e] <= wr_tag;
      end
    end
  end

  assign lk_hit_o = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);

  // R5: a written line is visible at the next cycle
  p_fill_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> valid_q[$past(wr_idx)]);

endmodule

// File: rtl/mlu_fill_engine.sv
module mlu_fill_engine #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned MISS_LAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] line_i,
  output logic              busy_o,
  output logic              last_o,
  output logic [ADDR_W-1:0] line_o
);

  localparam int unsigned CNT_W = $clog2(MISS_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(MISS_LAT - 1);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ADDR_W-1:0] line_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CNT_LOAD;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (start_i) begin
      line_q <= line_i;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == '0);
  assign line_o = line_q;

  // R6: a fill is never launched on top of an outstanding one
  p_single_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |-> !busy_q);

  // R3: a launched fill runs its full count
  p_fill_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (busy_q && cnt_q == CNT_LOAD));

  // R5: the fill keeps running in the background until its last cycle
  p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> busy_q);

endmodule

// File: rtl/mlu_access_ctrl.sv
module mlu_access_ctrl
  import mlu_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              no_replay_i,
  output logic [ADDR_W-1:0] lk_addr_o,
  input  logic              lk_hit_i,
  input  logic              fill_busy_i,
  input  logic              fill_last_i,
  input  logic [ADDR_W-1:0] fill_line_i,
  output logic              fill_start_o,
  output logic [ADDR_W-1:0] fill_line_o,
  output logic              ready_o,
  output logic              done_o,
  output logic              replay_o
);

  unit_state_e       state_q, state_d;
  logic [ADDR_W-1:0] held_q;
  logic              held_en;
  logic              idle;

  assign idle      = (state_q == UNIT_IDLE);
  assign lk_addr_o = idle ? addr_i : held_q;
  assign ready_o   = idle;

  always_comb begin
    state_d      = state_q;
    held_en      = 1'b0;
    done_o       = 1'b0;
    replay_o     = 1'b0;
    fill_start_o = 1'b0;
    fill_line_o  = lk_addr_o;
    if (idle) begin
      if (start_i) begin
        if (lk_hit_i) begin
          done_o = 1'b1;
        end else begin
          replay_o     = !no_replay_i;
          fill_start_o = !fill_busy_i;
          if (no_replay_i) begin
            state_d = UNIT_STALL;
            held_en = 1'b1;
          end
        end
      end
    end else begin
      if (fill_last_i && (fill_line_i == held_q)) begin
        done_o  = 1'b1;
        state_d = UNIT_IDLE;
      end else if (lk_hit_i) begin
        done_o  = 1'b1;
        state_d = UNIT_IDLE;
      end else if (!fill_busy_i) begin
        fill_start_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= UNIT_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk) begin
    if (held_en) begin
      held_q <= addr_i;
    end
  end

  // R4: completion and cancellation never coincide
  p_done_or_replay_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && replay_o));

  // R3: a stall ends with done and ready comes back next cycle
  p_ready_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !ready_o) |=> ready_o);

  // R8: no replay is raised while the unit is busy
  p_no_replay_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_o |-> !replay_o);

endmodule

// File: rtl/mlu_replay_arb.sv
module mlu_replay_arb #(
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned TID_W      = 2,
  parameter int unsigned STG_W      = 2
) (
  input  logic [NUM_STAGES-1:0]       req_i,
  input  logic [NUM_STAGES*TID_W-1:0] tid_i,
  output logic                        en_o,
  output logic [TID_W-1:0]            tid_o,
  output logic [STG_W-1:0]            stage_o
);

  logic [NUM_STAGES-1:0] grant;

  // later stages overwrite earlier ones, so the latest requester wins
  always_comb begin
    grant   = '0;
    tid_o   = '0;
    stage_o = '0;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (req_i[s]) begin
        grant   = '0;
        grant[s] = 1'b1;
        tid_o   = tid_i[s*TID_W +: TID_W];
        stage_o = STG_W'(s);
      end
    end
  end

  assign en_o = |grant;

  // R9: at most one stage granted, and the latest requester holds it
  always_comb begin
    p_grant_onehot_r9: assert ($onehot0(grant));
    p_latest_wins_r9: assert (!req_i[NUM_STAGES-1] || grant[NUM_STAGES-1]);
  end

endmodule

// File: rtl/mlu_top.sv
module mlu_top
  import mlu_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned IDX_W      = 2,
  parameter int unsigned TID_W      = 2,
  parameter int unsigned MISS_LAT   = 10,
  parameter int unsigned NUM_STAGES = 4,
  parameter int unsigned UNIT_STAGE = 2,
  localparam int unsigned STG_W     = idx_bits(NUM_STAGES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start_i,
  input  logic [TID_W-1:0]            tid_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic                        no_replay_i,
  input  logic [NUM_STAGES-1:0]       peer_req_i,
  input  logic [NUM_STAGES*TID_W-1:0] peer_tid_i,
  output logic                        ready_o,
  output logic                        done_o,
  output logic                        unit_replay_o,
  output logic                        replay_en_o,
  output logic [TID_W-1:0]            replay_tid_o,
  output logic [STG_W-1:0]            replay_stage_o
);

  logic [ADDR_W-1:0] lk_addr;
  logic              lk_hit;
  logic              fill_start;
  logic [ADDR_W-1:0] fill_req_line;
  logic              fill_busy;
  logic              fill_last;
  logic [ADDR_W-1:0] fill_line;

  logic [NUM_STAGES-1:0]       req_m;
  logic [NUM_STAGES*TID_W-1:0] tid_m;

  mlu_tag_table #(
    .ADDR_W (ADDR_W),
    .IDX_W  (IDX_W)
  ) tags_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_addr_i (lk_addr),
    .lk_hit_o  (lk_hit),
    .wr_en_i   (fill_last),
    .wr_addr_i (fill_line)
  );

  mlu_fill_engine #(
    .ADDR_W   (ADDR_W),
    .MISS_LAT (MISS_LAT)
  ) fill_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (fill_start),
    .line_i  (fill_req_line),
    .busy_o  (fill_busy),
    .last_o  (fill_last),
    .line_o  (fill_line)
  );

  mlu_access_ctrl #(
    .ADDR_W (ADDR_W)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .addr_i       (addr_i),
    .no_replay_i  (no_replay_i),
    .lk_addr_o    (lk_addr),
    .lk_hit_i     (lk_hit),
    .fill_busy_i  (fill_busy),
    .fill_last_i  (fill_last),
    .fill_line_i  (fill_line),
    .fill_start_o (fill_start),
    .fill_line_o  (fill_req_line),
    .ready_o      (ready_o),
    .done_o       (done_o),
    .replay_o     (unit_replay_o)
  );

  // merge the unit's own request into its stage slot
  always_comb begin
    req_m = peer_req_i;
    tid_m = peer_tid_i;
    if (unit_replay_o) begin
      req_m[UNIT_STAGE] = 1'b1;
      tid_m[UNIT_STAGE*TID_W +: TID_W] = tid_i;
    end
  end

  mlu_replay_arb #(
    .NUM_STAGES (NUM_STAGES),
    .TID_W      (TID_W),
    .STG_W      (STG_W)
  ) arb_i (
    .req_i   (req_m),
    .tid_i   (tid_m),
    .en_o    (replay_en_o),
    .tid_o   (replay_tid_o),
    .stage_o (replay_stage_o)
  );

  // R4: replay only when permitted at the start cycle
  p_replay_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    unit_replay_o |-> (!no_replay_i && start_i));

  // R10: the unit's request always reaches the arbiter output
  p_unit_seen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    unit_replay_o |-> (replay_en_o && replay_stage_o >= STG_W'(UNIT_STAGE)));

endmodule

// File: tb/mlu_top_tb_top.sv
module mlu_top_tb_top;

  localparam int unsigned ADDR_W = 8;
  localparam int unsigned TID_W  = 2;
  localparam int unsigned NST    = 4;

  logic              clk;
  logic              rst_n;
  logic              start;
  logic [TID_W-1:0]  tid;
  logic [ADDR_W-1:0] addr;
  logic              nrep;
  logic [NST-1:0]    preq;
  logic [NST*TID_W-1:0] ptid;
  logic              ready, done, ureq, ren;
  logic [TID_W-1:0]  rtid;
  logic [1:0]        rstg;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  mlu_top dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .tid_i(tid), .addr_i(addr),
    .no_replay_i(nrep), .peer_req_i(preq), .peer_tid_i(ptid),
    .ready_o(ready), .done_o(done), .unit_replay_o(ureq),
    .replay_en_o(ren), .replay_tid_o(rtid), .replay_stage_o(rstg)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // {peer req[4], peer tids[8], exp en, exp tid[2], exp stage[2]}
  localparam logic [16:0] ARB_VEC [8] = '{
    {4'b0000, 8'b00000000, 1'b0, 2'd0, 2'd0},
    {4'b0001, 8'b00000011, 1'b1, 2'd3, 2'd0},
    {4'b0011, 8'b00001001, 1'b1, 2'd2, 2'd1},
    {4'b0101, 8'b00110001, 1'b1, 2'd3, 2'd2},
    {4'b1111, 8'b01101100, 1'b1, 2'd1, 2'd3},
    {4'b1000, 8'b10000000, 1'b1, 2'd2, 2'd3},
    {4'b0110, 8'b00011000, 1'b1, 2'd1, 2'd2},
    {4'b1010, 8'b11000100, 1'b1, 2'd3, 2'd3}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic drive(input logic s, input logic [ADDR_W-1:0] a,
                       input logic [TID_W-1:0] t, input logic nr);
    start = s; addr = a; tid = t; nrep = nr;
    #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      tick;
      drive(1'b0, '0, '0, 1'b0);
    end
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R1..: got timeout expected completion");
    finish_run;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; tid = '0; addr = '0; nrep = 1'b0;
    preq = '0; ptid = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ready in reset", ready, 1);
    chk("R1 done in reset", done, 0);
    tick;
    rst_n = 1'b1;
    #1;
    chk("R1 ready after reset", ready, 1);
    chk("R1 replay_en after reset", ren, 0);
    chk("R1 unit_replay after reset", ureq, 0);

    // R9 arbiter table, unit idle
    for (int v = 0; v < 8; v++) begin
      tick;
      preq = ARB_VEC[v][16:13];
      ptid = ARB_VEC[v][12:5];
      #1;
      chk($sformatf("R9 vec%0d en", v), ren, ARB_VEC[v][4]);
      chk($sformatf("R9 vec%0d tid", v), rtid, ARB_VEC[v][3:2]);
      chk($sformatf("R9 vec%0d stage", v), rstg, ARB_VEC[v][1:0]);
    end
    tick;
    preq = '0; ptid = '0;
    idle(2);

    // R1/R4: first access misses, replay allowed
    tick; drive(1'b1, 8'h11, 2'd1, 1'b0);
    chk("R4 unit_replay", ureq, 1);
    chk("R4 replay_en", ren, 1);
    chk("R4 replay_tid", rtid, 1);
    chk("R10 replay_stage unit", rstg, 2);
    chk("R4 done", done, 0);
    chk("R4 ready", ready, 1);
    for (int k = 1; k <= 9; k++) begin
      tick; drive(1'b0, '0, '0, 1'b0);
      chk($sformatf("R4 ready c0+%0d", k), ready, 1);
    end
    // R5: c0+10 still misses, c0+11 hits
    tick; drive(1'b1, 8'h11, 2'd1, 1'b0);
    chk("R5 miss at c0+10 done", done, 0);
    chk("R5 miss at c0+10 replay", ureq, 1);
    tick; drive(1'b1, 8'h11, 2'd2, 1'b0);
    chk("R5 hit at c0+11 done", done, 1);
    chk("R5 hit at c0+11 no replay", ren, 0);

    // R2: hit, ready stays
    tick; drive(1'b1, 8'h11, 2'd3, 1'b1);
    chk("R2 hit done", done, 1);
    chk("R2 hit ready", ready, 1);
    tick; drive(1'b0, '0, '0, 1'b0);
    chk("R2 ready after hit", ready, 1);
    chk("R2 done after hit", done, 0);

    // R3: stalled miss, R8 start ignored during stall
    tick; drive(1'b1, 8'h22, 2'd2, 1'b1);
    chk("R3 start done", done, 0);
    chk("R3 no replay", ureq, 0);
    for (int k = 1; k <= 10; k++) begin
      tick;
      if (k == 4) drive(1'b1, 8'h11, 2'd0, 1'b0);
      else        drive(1'b0, '0, '0, 1'b1);
      chk($sformatf("R3 ready c0+%0d", k), ready, 0);
      if (k == 4) begin
        chk("R8 start ignored done", done, 0);
        chk("R8 start ignored replay", ureq, 0);
      end else begin
        chk($sformatf("R3 done c0+%0d", k), done, (k == 10) ? 1 : 0);
      end
    end
    tick; drive(1'b0, '0, '0, 1'b0);
    chk("R3 ready c0+11", ready, 1);
    chk("R3 done c0+11", done, 0);
    tick; drive(1'b1, 8'h22, 2'd2, 1'b1);
    chk("R3 line hits afterwards", done, 1);
    idle(2);

    // R6: second miss during fill starts no fill
    tick; drive(1'b1, 8'h33, 2'd0, 1'b0);
    chk("R6 first miss replay", ureq, 1);
    tick; drive(1'b0, '0, '0, 1'b0);
    tick; drive(1'b1, 8'h34, 2'd1, 1'b0);
    chk("R6 second miss replay", ureq, 1);
    chk("R6 second miss done", done, 0);
    for (int k = 3; k <= 11; k++) begin
      tick; drive(1'b0, '0, '0, 1'b0);
    end
    tick; drive(1'b1, 8'h33, 2'd0, 1'b1);
    chk("R6 first line hits", done, 1);
    tick; drive(1'b1, 8'h34, 2'd1, 1'b0);
    chk("R6 second line misses done", done, 0);
    chk("R6 second line misses replay", ureq, 1);
    idle(12);

    // R7: stall on another line queued behind a fill
    tick; drive(1'b1, 8'h45, 2'd0, 1'b0);
    chk("R7 fill launch replay", ureq, 1);
    tick; drive(1'b0, '0, '0, 1'b0);
    tick; drive(1'b1, 8'h4A, 2'd3, 1'b1);
    chk("R7 other-line stall done", done, 0);
    chk("R7 other-line stall replay", ureq, 0);
    for (int k = 3; k <= 22; k++) begin
      tick; drive(1'b0, '0, '0, 1'b0);
      chk($sformatf("R7 other ready c0+%0d", k), ready, (k == 22) ? 1 : 0);
      chk($sformatf("R7 other done c0+%0d", k), done, (k == 21) ? 1 : 0);
    end
    idle(2);

    // R7: stall on the line already being filled
    tick; drive(1'b1, 8'h56, 2'd1, 1'b0);
    chk("R7 same-line launch replay", ureq, 1);
    idle(2);
    tick; drive(1'b1, 8'h56, 2'd1, 1'b1);
    chk("R7 same-line stall done", done, 0);
    for (int k = 4; k <= 11; k++) begin
      tick; drive(1'b0, '0, '0, 1'b0);
      chk($sformatf("R7 same done c0+%0d", k), done, (k == 10) ? 1 : 0);
      chk($sformatf("R7 same ready c0+%0d", k), ready, (k == 11) ? 1 : 0);
    end

    // R11: 0x56 replaced 0x4A at index 2
    tick; drive(1'b1, 8'h56, 2'd1, 1'b1);
    chk("R11 new line hits", done, 1);
    tick; drive(1'b1, 8'h4A, 2'd0, 1'b0);
    chk("R11 evicted line misses done", done, 0);
    chk("R11 evicted line misses replay", ureq, 1);
    idle(12);

    // R10: merge of the unit request with peers
    tick;
    preq = 4'b1000; ptid = 8'b10_00_00_00;
    drive(1'b1, 8'h77, 2'd1, 1'b0);
    chk("R10 later peer wins tid", rtid, 2);
    chk("R10 later peer wins stage", rstg, 3);
    chk("R10 unit still requests", ureq, 1);
    tick;
    preq = 4'b0010; ptid = 8'b00_00_11_00;
    drive(1'b1, 8'h77, 2'd1, 1'b0);
    chk("R10 unit beats earlier tid", rtid, 1);
    chk("R10 unit beats earlier stage", rstg, 2);
    tick;
    preq = 4'b0100; ptid = 8'b00_11_00_00;
    drive(1'b1, 8'h77, 2'd0, 1'b0);
    chk("R10 unit tid replaces peer at own stage", rtid, 0);
    chk("R10 own stage", rstg, 2);
    tick;
    preq = '0; ptid = '0;
    drive(1'b0, '0, '0, 1'b0);
    chk("R9 no request en", ren, 0);
    idle(12);

    finish_run;
  end

endmodule